// File: doc/BRIEF.md
# Leveled Interrupt Mask and Vector Arbiter

This block sits between a processor core's interrupt sources and its exception sequencer. It gathers a set of peripheral request lines, each given a priority level from 1 to 7 by its own level input, together with seven software interrupt requests, one per level. At every instruction boundary it looks at what is pending, compares the best level against the 3-bit mask held in the processor status word, and, if an interrupt is to be taken, raises a one-cycle take pulse together with the winning vector number, its byte offset into the vector table and the mask value the core must load when it enters the handler.

Levels 1 to 6 are level-sensitive: a source counts only while its line is high and only when its level is strictly above the current mask. Level 7 is the non-maskable class: it is captured on the rising edge of the request into a per-source latch, is taken even when the mask is 7, and the latch is released only when that source's vector is actually taken. Sampling is skipped when the core flags that it is executing the first instruction of a handler, so an interrupt cannot preempt a handler before its first instruction has run. Stack frame construction, vector fetch and condition codes belong to the core, not to this block.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, take_irq, vec_num, vec_offset and new_mask are all 0, no level-7 request is latched, and a boundary with no request asserted yields no take.
- R2: A request at a level from 1 to 6 is taken only if its level is strictly greater than sr_mask; a request at or below the mask, or at level 0, is never taken.
- R3: A level-7 request is taken on its rising edge regardless of sr_mask (including 7); a level-7 line that stays high is taken once only, until it falls and rises again.
- R4: When several eligible requests are pending, the one with the highest level wins.
- R5: Among eligible requests of equal level, the one with the lowest vector number wins.
- R6: Requests are evaluated only in a cycle with insn_boundary high; take_irq is a registered pulse, high for exactly the one cycle that follows such a boundary cycle.
- R7: A boundary cycle with first_of_handler high takes nothing, and pending requests (including latched level-7 edges) stay pending for a later boundary.
- R8: Peripheral source j (bit j of periph_req) has vector number 64 + j; the software request at level L (bit L-1 of swi_req) has vector number 103 - L, so level 7 uses 96 and level 1 uses 102.
- R9: vec_offset equals four times vec_num (for example vector 64 gives 0x100).
- R10: On a take, new_mask equals the level of the accepted request.
- R11: A latched level-7 edge stays pending after its request line drops and is cleared in the cycle its vector is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | NUM_PERIPH | Peripheral request lines, bit j maps to vector 64 + j |
| periph_level | input | 3*NUM_PERIPH | Level of each peripheral source, bits [3j+2:3j] for source j; 0 disables |
| swi_req | input | 7 | Software requests, bit L-1 requests level L |
| sr_mask | input | 3 | Current interrupt mask from the status word |
| insn_boundary | input | 1 | High for one cycle at each instruction boundary |
| first_of_handler | input | 1 | High when the boundary ends the first instruction of a handler |
| take_irq | output | 1 | One-cycle pulse: an interrupt is accepted |
| vec_num | output | 8 | Vector number of the accepted interrupt (held until the next take) |
| vec_offset | output | 10 | Byte offset of the vector, vec_num times 4 |
| new_mask | output | 3 | Mask value to load on handler entry, the accepted level |

## Verification
On every cycle the assertions check that a take follows a boundary cycle that was not flagged as a handler's first instruction, that a maskable take was strictly above the mask seen at the boundary, that the reported vector lies inside the peripheral or software window, and that every level-7 rising edge is latched and every taken latch is released. Which source wins among several, the exact vector and offset values, the tie rule, the one-shot behaviour of a held level-7 line and the survival of a latched edge across a suppressed boundary are only shown by the bench's table rows and directed sequences.

// File: rtl/irq_arb_pkg.sv
// Package: shared widths and constants of the interrupt arbiter.
// Assumes a 3-bit level field and 8-bit vector numbers.
package irq_arb_pkg;
    localparam int LVL_W           = 3;
    localparam int MAX_LVL         = (1 << LVL_W) - 1;
    localparam int VEC_W           = 8;
    localparam int OFS_W           = VEC_W + 2;
    localparam int PERIPH_VEC_BASE = 64;
    localparam int SWI_VEC_BASE    = 96;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_src_map.sv
// irq_src_map: flattens peripheral and software requests into one source
// list ordered by rising vector number, with each source's level and vector.
// Assumes NUM_PERIPH <= 32 so peripheral vectors stay below the software ones.
module irq_src_map
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 30,
    localparam int NUM_SWI   = MAX_LVL,
    localparam int NUM_SRC   = NUM_PERIPH + NUM_SWI
) (
    input  logic [NUM_PERIPH-1:0]       periph_req,
    input  logic [NUM_PERIPH*LVL_W-1:0] periph_level,
    input  logic [NUM_SWI-1:0]          swi_req,
    output logic [NUM_SRC-1:0]          src_req,
    output lvl_t [NUM_SRC-1:0]          src_lvl,
    output vec_t [NUM_SRC-1:0]          src_vec
);
    // Peripheral sources keep their own level and sit at the low vectors.
    for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_periph
        assign src_req[j] = periph_req[j];
        assign src_lvl[j] = periph_level[j*LVL_W +: LVL_W];
        assign src_vec[j] = VEC_W'(PERIPH_VEC_BASE + j);
    end

    // Software sources: entry k has level MAX_LVL-k and vector base+k.
    for (genvar k = 0; k < NUM_SWI; k++) begin : g_swi
        assign src_req[NUM_PERIPH+k] = swi_req[MAX_LVL-1-k];
        assign src_lvl[NUM_PERIPH+k] = LVL_W'(MAX_LVL - k);
        assign src_vec[NUM_PERIPH+k] = VEC_W'(SWI_VEC_BASE + k);
    end
endmodule

// File: rtl/irq_edge_latch.sv
// irq_edge_latch: captures rising edges of requests at the top level and
// holds them until the arbiter reports the source as taken.
// Assumes clr is a one-hot (or zero) vector from the arbiter.
module irq_edge_latch
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 37
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  lvl_t [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend7
);
    logic [NUM_SRC-1:0] req7;
    logic [NUM_SRC-1:0] req7_q;
    logic [NUM_SRC-1:0] rise7;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_req7
        assign req7[i] = src_req[i] && (src_lvl[i] == LVL_W'(MAX_LVL));
    end
    assign rise7 = req7 & ~req7_q;

    // Remember last request state to spot rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) req7_q <= '0;
        else        req7_q <= req7;
    end

    // Set on an edge, release on take; a fresh edge wins over a release.
    always_ff @(posedge clk) begin
        if (!rst_n) pend7 <= '0;
        else        pend7 <= (pend7 & ~clr) | rise7;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R3: every rising edge of a level-7 request is held pending.
        p_edge_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req7[i] && !req7_q[i]) |=> pend7[i]);
        // R11: a taken latch is released unless a new edge arrived with it.
        p_latch_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !(req7[i] && !req7_q[i])) |=> !pend7[i]);
    end
endmodule

// File: rtl/irq_winner_select.sv
// irq_winner_select: picks the eligible source with the highest level,
// breaking ties by lowest index (sources are ordered by vector number).
// Assumes src order matches ascending vector number.
module irq_winner_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 37,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  lvl_t [NUM_SRC-1:0] src_lvl,
    input  vec_t [NUM_SRC-1:0] src_vec,
    input  logic [NUM_SRC-1:0] pend7,
    input  lvl_t               mask,
    output logic               win_valid,
    output lvl_t               win_lvl,
    output vec_t               win_vec,
    output logic [NUM_SRC-1:0] win_onehot
);
    logic [NUM_SRC-1:0] elig;
    logic [IDX_W-1:0]   win_idx;

    // Top level counts only through its edge latch; others must beat the mask.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = (src_lvl[i] == LVL_W'(MAX_LVL)) ? pend7[i]
                       : (src_req[i] && (src_lvl[i] > mask));
    end

    // Strict compare keeps the lowest index among equal levels.
    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        win_vec   = '0;
        win_idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (src_lvl[i] > win_lvl)) begin
                win_valid = 1'b1;
                win_lvl   = src_lvl[i];
                win_vec   = src_vec[i];
                win_idx   = IDX_W'(i);
            end
        end
    end

    assign win_onehot = win_valid ? (NUM_SRC'(1) << win_idx) : '0;
endmodule

// File: rtl/irq_level_arbiter.sv
// irq_level_arbiter: top of the leveled interrupt arbiter. Samples requests
// at instruction boundaries (not on a handler's first instruction) and
// registers take pulse, vector, offset and new mask.
// Assumes insn_boundary is a single-cycle strobe per instruction.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 30,
    localparam int NUM_SWI   = MAX_LVL,
    localparam int NUM_SRC   = NUM_PERIPH + NUM_SWI
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PERIPH-1:0]       periph_req,
    input  logic [NUM_PERIPH*LVL_W-1:0] periph_level,
    input  logic [NUM_SWI-1:0]          swi_req,
    input  logic [LVL_W-1:0]            sr_mask,
    input  logic                        insn_boundary,
    input  logic                        first_of_handler,
    output logic                        take_irq,
    output logic [VEC_W-1:0]            vec_num,
    output logic [OFS_W-1:0]            vec_offset,
    output logic [LVL_W-1:0]            new_mask
);
    logic [NUM_SRC-1:0] src_req;
    lvl_t [NUM_SRC-1:0] src_lvl;
    vec_t [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] pend7;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] win_onehot;
    logic               win_valid;
    lvl_t               win_lvl;
    vec_t               win_vec;
    logic               sample;

    irq_src_map #(.NUM_PERIPH(NUM_PERIPH)) u_map (
        .periph_req  (periph_req),
        .periph_level(periph_level),
        .swi_req     (swi_req),
        .src_req     (src_req),
        .src_lvl     (src_lvl),
        .src_vec     (src_vec)
    );

    irq_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_req(src_req),
        .src_lvl(src_lvl),
        .clr    (clr),
        .pend7  (pend7)
    );

    irq_winner_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .src_req   (src_req),
        .src_lvl   (src_lvl),
        .src_vec   (src_vec),
        .pend7     (pend7),
        .mask      (sr_mask),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .win_vec   (win_vec),
        .win_onehot(win_onehot)
    );

    assign sample = insn_boundary && !first_of_handler;
    // Release a level-7 latch only when its own vector is taken.
    assign clr = (sample && (win_lvl == LVL_W'(MAX_LVL))) ? win_onehot : '0;

    // Register the decision; vector fields hold until the next take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_irq   <= 1'b0;
            vec_num    <= '0;
            vec_offset <= '0;
            new_mask   <= '0;
        end else begin
            take_irq <= sample && win_valid;
            if (sample && win_valid) begin
                vec_num    <= win_vec;
                vec_offset <= {win_vec, 2'b00};
                new_mask   <= win_lvl;
            end
        end
    end

    // R6: a take is always the answer to a boundary cycle.
    p_take_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(insn_boundary));
    // R7: no take comes from a handler's first instruction.
    p_take_not_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(first_of_handler));
    // R2: a maskable take was above the mask in force at the boundary.
    p_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && new_mask != LVL_W'(MAX_LVL)) |-> (new_mask > $past(sr_mask)));
    // R8: the vector lies in the peripheral or software window.
    p_vec_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ((vec_num >= VEC_W'(PERIPH_VEC_BASE)
                       && vec_num < VEC_W'(PERIPH_VEC_BASE + NUM_PERIPH))
                   || (vec_num >= VEC_W'(SWI_VEC_BASE)
                       && vec_num < VEC_W'(SWI_VEC_BASE + NUM_SWI))));
endmodule

// File: tb/irq_level_arbiter_tb.sv
// Bench for irq_level_arbiter: a table of request patterns walked by one
// loop, then directed sequences for reset, sampling and level-7 edges.
module irq_level_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 30;

    typedef struct packed {
        logic       en_a;
        logic [4:0] idx_a;
        logic [2:0] lvl_a;
        logic       en_b;
        logic [4:0] idx_b;
        logic [2:0] lvl_b;
        logic [6:0] swi;
        logic [2:0] mask;
        logic       exp_take;
        logic [7:0] exp_vec;
        logic [2:0] exp_lvl;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TBL [NROWS] = '{
        '{1'b1,5'd3,3'd2,  1'b0,5'd0,3'd0,  7'h00,3'd1, 1'b1,8'd67,3'd2}, // R2 R8 above mask
        '{1'b1,5'd3,3'd2,  1'b0,5'd0,3'd0,  7'h00,3'd2, 1'b0,8'd0,3'd0},  // R2 equal to mask
        '{1'b1,5'd5,3'd3,  1'b1,5'd10,3'd5, 7'h00,3'd0, 1'b1,8'd74,3'd5}, // R4 higher level
        '{1'b1,5'd20,3'd4, 1'b1,5'd7,3'd4,  7'h00,3'd0, 1'b1,8'd71,3'd4}, // R5 tie
        '{1'b0,5'd0,3'd0,  1'b0,5'd0,3'd0,  7'h04,3'd0, 1'b1,8'd100,3'd3},// R8 swi level 3
        '{1'b1,5'd29,3'd6, 1'b0,5'd0,3'd0,  7'h20,3'd0, 1'b1,8'd93,3'd6}, // R5 periph vs swi
        '{1'b0,5'd0,3'd0,  1'b0,5'd0,3'd0,  7'h40,3'd7, 1'b1,8'd96,3'd7}, // R3 swi level 7
        '{1'b1,5'd0,3'd7,  1'b0,5'd0,3'd0,  7'h00,3'd7, 1'b1,8'd64,3'd7}, // R3 periph level 7
        '{1'b1,5'd0,3'd0,  1'b0,5'd0,3'd0,  7'h00,3'd0, 1'b0,8'd0,3'd0},  // R2 level 0
        '{1'b1,5'd12,3'd1, 1'b0,5'd0,3'd0,  7'h00,3'd0, 1'b1,8'd76,3'd1}, // R10 level 1
        '{1'b1,5'd1,3'd6,  1'b0,5'd0,3'd0,  7'h40,3'd3, 1'b1,8'd96,3'd7}, // R4 level 7 wins
        '{1'b1,5'd2,3'd5,  1'b0,5'd0,3'd0,  7'h00,3'd6, 1'b0,8'd0,3'd0}   // R2 below mask
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic [NP*3-1:0] periph_level = '0;
    logic [6:0]    swi_req = '0;
    logic [2:0]    sr_mask = '0;
    logic          insn_boundary = 1'b0;
    logic          first_of_handler = 1'b0;
    logic          take_irq;
    logic [7:0]    vec_num;
    logic [9:0]    vec_offset;
    logic [2:0]    new_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_arbiter #(.NUM_PERIPH(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
        .periph_level(periph_level), .swi_req(swi_req), .sr_mask(sr_mask),
        .insn_boundary(insn_boundary), .first_of_handler(first_of_handler),
        .take_irq(take_irq), .vec_num(vec_num), .vec_offset(vec_offset),
        .new_mask(new_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        periph_req = '0; periph_level = '0; swi_req = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(input int idx, input logic [2:0] lvl);
        periph_level[idx*3 +: 3] = lvl;
        periph_req[idx] = 1'b1;
    endtask

    // One boundary cycle; returns at the negedge after the sampling edge.
    task automatic strobe(input logic first);
        @(negedge clk);
        insn_boundary = 1'b1; first_of_handler = first;
        @(negedge clk);
        insn_boundary = 1'b0; first_of_handler = 1'b0;
    endtask

    task automatic chk_take(input string tag, input logic [7:0] v, input logic [2:0] l);
        chk({tag, " take"}, 32'(take_irq), 32'd1);
        chk({tag, " vector"}, 32'(vec_num), 32'(v));
        chk({tag, " offset R9"}, 32'(vec_offset), 32'(v) * 4);
        chk({tag, " new mask R10"}, 32'(new_mask), 32'(l));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 take after reset", 32'(take_irq), 32'd0);
        chk("R1 vector after reset", 32'(vec_num), 32'd0);
        chk("R1 offset after reset", 32'(vec_offset), 32'd0);
        chk("R1 mask after reset", 32'(new_mask), 32'd0);
        strobe(1'b0);
        chk("R1 idle boundary", 32'(take_irq), 32'd0);

        // Table walk: R2 R3 R4 R5 R8 R9 R10
        for (int r = 0; r < NROWS; r++) begin
            clear_all();
            sr_mask = TBL[r].mask;
            if (TBL[r].en_a) set_src(TBL[r].idx_a, TBL[r].lvl_a);
            if (TBL[r].en_b) set_src(TBL[r].idx_b, TBL[r].lvl_b);
            swi_req = TBL[r].swi;
            @(negedge clk);
            strobe(1'b0);
            if (TBL[r].exp_take)
                chk_take($sformatf("table row %0d R4 R5 R8", r), TBL[r].exp_vec, TBL[r].exp_lvl);
            else
                chk($sformatf("table row %0d R2 held off", r), 32'(take_irq), 32'd0);
        end

        // R6: no sampling without a boundary strobe
        clear_all();
        sr_mask = 3'd0;
        set_src(4, 3'd5);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R6 no boundary", 32'(take_irq), 32'd0);
        end
        // R7: first instruction of a handler does not sample
        strobe(1'b1);
        chk("R7 first of handler", 32'(take_irq), 32'd0);
        strobe(1'b0);
        chk_take("R6 boundary takes", 8'd68, 3'd5);
        @(negedge clk);
        chk("R6 one-cycle pulse", 32'(take_irq), 32'd0);

        // R11: latched edge survives request drop and a suppressed boundary
        clear_all();
        sr_mask = 3'd7;
        set_src(9, 3'd7);
        @(negedge clk);
        @(negedge clk);
        periph_req[9] = 1'b0;
        strobe(1'b1);
        chk("R11 suppressed boundary", 32'(take_irq), 32'd0);
        strobe(1'b0);
        chk_take("R11 latched edge taken", 8'd73, 3'd7);
        strobe(1'b0);
        chk("R11 latch cleared", 32'(take_irq), 32'd0);

        // R3: held level-7 line is taken only once
        clear_all();
        sr_mask = 3'd7;
        set_src(15, 3'd7);
        @(negedge clk);
        strobe(1'b0);
        chk_take("R3 level-7 edge", 8'd79, 3'd7);
        strobe(1'b0);
        chk("R3 held line not retaken", 32'(take_irq), 32'd0);
        periph_req[15] = 1'b0;
        @(negedge clk);
        periph_req[15] = 1'b1;
        @(negedge clk);
        strobe(1'b0);
        chk_take("R3 new edge retaken", 8'd79, 3'd7);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule